// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Character Timeout

This block turns an asynchronous serial line into bytes and hands them to a host. A sampling-clock enable paces the block. It runs at 16, 8 or 4 enable pulses per bit. It finds a start bit on a falling edge and confirms it at the middle of the bit. It then gathers the data bits least significant bit first and checks the optional parity bit and the first stop bit. Each finished character goes into a 32-entry queue together with three error tags.

The host sees the oldest entry at all times: the byte, its tags, the fill level and a sticky overrun flag. A one-cycle read strobe removes that entry. A data-ready output asserts either for any stored character or only once the fill reaches a selectable threshold. A timeout output asserts when stored data has gone untouched for longer than about four characters. This lets the host collect a short tail of data that never reaches the threshold.

Top module: `uart_rx_path`

## Requirements
- R1: While the receiver is idle, a high-to-low change of `rxIn` seen on two consecutive enable pulses begins a frame. The start bit is sampled 8, 4 or 2 enable pulses later for `osMode` 0 (16X), 1 (8X) and 2 or 3 (4X). Cycles without `sampleTick` change nothing.
- R2: If `rxIn` is high at the start-bit check, the receiver returns to idle and stores nothing.
- R3: Data bits are sampled one full bit period (16, 8 or 4 pulses) apart, least significant bit first. `wordLen` 0..3 selects 5..8 data bits. Unused upper bits of `headData` read as zero.
- R4: With `parityEn` set, a parity bit follows the data. `parityOdd` 1 expects an odd count of ones over data plus parity, and 0 expects an even count. A mismatch sets `headParErr` for that character.
- R5: The queue holds 32 entries of 8 data bits plus 3 tags and delivers them in arrival order. `level` reports the number of stored entries.
- R6: A `readStrobe` on a non-empty queue removes the head. In the next cycle `headData` and all three tags already show the following entry.
- R7: `headFrmErr` is set when the first stop bit is sampled low. `headBrk` is set when every data bit, the parity bit (if enabled) and the stop bit are all sampled low.
- R8: A character that finishes while the queue holds 32 entries, with no read in the same cycle, is dropped and sets `overrun`. `overrun` stays set until the next `readStrobe`. When a read and a finished character fall in the same cycle on a full queue, the character is stored and `overrun` stays clear.
- R9: With `trigMode` 0, `dataReady` is high whenever `level` is non-zero. With `trigMode` 1, it is high when `level` is at least 8, 16, 24 or 28 for `trigSel` 0, 1, 2 or 3.
- R10: `timeout` rises after (4 x frame bits + 12) bit periods pass with the queue non-empty and with no stored character and no read. Frame bits are 1 start bit + data bits + parity bit + stop bits, where `twoStop` selects 2 stop bits instead of 1.
- R11: A finished character or a read clears `timeout` and restarts its count. An empty queue holds the count and the flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleTick | input | 1 | Sampling-clock enable, one pulse per oversample |
| rxIn | input | 1 | Serial line, idles high |
| osMode | input | 2 | Oversampling select: 0 = 16X, 1 = 8X, 2/3 = 4X |
| wordLen | input | 2 | Data bits minus 5 |
| parityEn | input | 1 | Parity bit present |
| parityOdd | input | 1 | 1 = odd parity, 0 = even parity |
| twoStop | input | 1 | Frame has two stop bits (used for the timeout length) |
| trigMode | input | 1 | 0 = ready on any data, 1 = ready at threshold |
| trigSel | input | 2 | Threshold select: 8, 16, 24, 28 |
| readStrobe | input | 1 | Remove the head entry |
| headData | output | 8 | Head entry data byte |
| headParErr | output | 1 | Head entry parity error tag |
| headFrmErr | output | 1 | Head entry framing error tag |
| headBrk | output | 1 | Head entry break tag |
| overrun | output | 1 | Sticky dropped-character flag |
| level | output | 6 | Number of stored entries |
| dataReady | output | 1 | Data-ready indication |
| timeout | output | 1 | Character timeout indication |

## Verification
Two events can land on the same clock edge: the stop-bit sample that stores a character, and a host read that frees an entry. This matters most when the queue is full, because the result decides between storing the character and dropping it as an overrun. The bench fills the queue to 32 entries. It then starts a frame and counts enable pulses from its first falling edge so that the read strobe lands on the exact stop-sample edge. It then expects `level` to stay at 32 and `overrun` to stay clear, and a full drain to return the surviving entries in order with the new character last.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rxStateT;

  // Strobes from the bit sequencer to the datapath, valid in one cycle.
  typedef struct packed {
    logic frameStart;
    logic dataShift;
    logic parSample;
    logic stopPush;
  } rxStrobeT;

  // One queue entry: byte plus three tags (11 bits).
  typedef struct packed {
    logic [7:0] data;
    logic       parErr;
    logic       frmErr;
    logic       brk;
  } rxEntryT;

  function automatic logic [4:0] bitTicks(input logic [1:0] mode);
    case (mode)
      2'd0:    bitTicks = 5'd16;
      2'd1:    bitTicks = 5'd8;
      default: bitTicks = 5'd4;
    endcase
  endfunction

endpackage

// File: rtl/uart_rx_ctrl.sv
module uart_rx_ctrl
  import uart_rx_pkg::*;
#(
  parameter int LIMIT_W = 7
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleTick,
  input  logic       rxIn,
  input  logic [1:0] osMode,
  input  logic [1:0] wordLen,
  input  logic       parityEn,
  input  logic       twoStop,
  input  logic       popEn,
  input  logic       levelZero,
  output rxStrobeT   strobe,
  output logic       timeout
);

  rxStateT    state;
  logic [3:0] cnt;
  logic [2:0] bitIdx;
  logic       prevRx;

  logic [4:0] fullTicks;
  logic [4:0] halfTicks;
  logic [4:0] cntNext;
  logic [4:0] target;
  logic       bitHit;
  logic [2:0] lastIdx;

  assign fullTicks = bitTicks(osMode);
  assign halfTicks = fullTicks >> 1;
  assign cntNext   = {1'b0, cnt} + 5'd1;
  assign target    = (state == ST_START) ? halfTicks : fullTicks;
  assign bitHit    = sampleTick && (cntNext == target);
  assign lastIdx   = 3'd4 + {1'b0, wordLen};

  always_comb begin
    strobe.frameStart = sampleTick && (state == ST_IDLE) && prevRx && !rxIn;
    strobe.dataShift  = bitHit && (state == ST_DATA);
    strobe.parSample  = bitHit && (state == ST_PAR);
    strobe.stopPush   = bitHit && (state == ST_STOP);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      bitIdx <= '0;
      prevRx <= 1'b1;
    end else if (sampleTick) begin
      prevRx <= rxIn;
      case (state)
        ST_IDLE: begin
          if (strobe.frameStart) begin
            state <= ST_START;
            cnt   <= '0;
          end
        end
        ST_START: begin
          if (bitHit) begin
            cnt    <= '0;
            bitIdx <= '0;
            state  <= rxIn ? ST_IDLE : ST_DATA;
          end else begin
            cnt <= cntNext[3:0];
          end
        end
        ST_DATA: begin
          if (bitHit) begin
            cnt <= '0;
            if (bitIdx == lastIdx) begin
              state <= parityEn ? ST_PAR : ST_STOP;
            end else begin
              bitIdx <= bitIdx + 3'd1;
            end
          end else begin
            cnt <= cntNext[3:0];
          end
        end
        ST_PAR: begin
          if (bitHit) begin
            cnt   <= '0;
            state <= ST_STOP;
          end else begin
            cnt <= cntNext[3:0];
          end
        end
        ST_STOP: begin
          if (bitHit) begin
            cnt   <= '0;
            state <= ST_IDLE;
          end else begin
            cnt <= cntNext[3:0];
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Character timeout: bit periods counted in a tick prescaler plus a bit counter.
  logic [LIMIT_W-1:0] frameBits;
  logic [LIMIT_W-1:0] bitLimit;
  logic [3:0]         tmoTick;
  logic [LIMIT_W-1:0] tmoBits;
  logic [4:0]         tmoTickNext;
  logic               tmoClear;

  assign frameBits   = LIMIT_W'(7) + LIMIT_W'(wordLen) + LIMIT_W'(parityEn) + LIMIT_W'(twoStop);
  assign bitLimit    = (frameBits << 2) + LIMIT_W'(12);
  assign tmoTickNext = {1'b0, tmoTick} + 5'd1;
  assign tmoClear    = strobe.stopPush || popEn || levelZero;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmoTick <= '0;
      tmoBits <= '0;
      timeout <= 1'b0;
    end else if (tmoClear) begin
      tmoTick <= '0;
      tmoBits <= '0;
      timeout <= 1'b0;
    end else if (sampleTick && !timeout) begin
      if (tmoTickNext == fullTicks) begin
        tmoTick <= '0;
        if (tmoBits + LIMIT_W'(1) == bitLimit) begin
          tmoBits <= '0;
          timeout <= 1'b1;
        end else begin
          tmoBits <= tmoBits + LIMIT_W'(1);
        end
      end else begin
        tmoTick <= tmoTickNext[3:0];
      end
    end
  end

  AST_FALSE_START: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_START && bitHit && rxIn) |=> (state == ST_IDLE)); // R2

  AST_TICK_GATE: assert property (@(posedge clk) disable iff (!rstN)
    !sampleTick |=> $stable(state)); // R1

  AST_TMO_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    timeout |-> !levelZero); // R11

  AST_TMO_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    popEn |=> !timeout); // R11

endmodule

// File: rtl/uart_rx_dp.sv
module uart_rx_dp
  import uart_rx_pkg::*;
#(
  parameter int DEPTH   = 32,
  parameter int PTR_W   = $clog2(DEPTH),
  parameter int LEVEL_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               rxIn,
  input  rxStrobeT           strobe,
  input  logic [1:0]         wordLen,
  input  logic               parityEn,
  input  logic               parityOdd,
  input  logic               popReq,
  output rxEntryT            headEntry,
  output logic [LEVEL_W-1:0] level,
  output logic               overrun,
  output logic               popEn
);

  logic [7:0] shReg;
  logic       parAcc;
  logic       allZero;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg   <= '0;
      parAcc  <= 1'b0;
      allZero <= 1'b1;
    end else if (strobe.frameStart) begin
      parAcc  <= 1'b0;
      allZero <= 1'b1;
    end else if (strobe.dataShift) begin
      shReg   <= {rxIn, shReg[7:1]};
      parAcc  <= parAcc ^ rxIn;
      allZero <= allZero & !rxIn;
    end else if (strobe.parSample) begin
      parAcc  <= parAcc ^ rxIn;
      allZero <= allZero & !rxIn;
    end
  end

  rxEntryT newEntry;
  always_comb begin
    newEntry.data   = shReg >> (2'd3 - wordLen);
    newEntry.parErr = parityEn && (parAcc != parityOdd);
    newEntry.frmErr = !rxIn;
    newEntry.brk    = allZero && !rxIn;
  end

  rxEntryT            mem [DEPTH];
  logic [PTR_W-1:0]   wrPtr;
  logic [PTR_W-1:0]   rdPtr;
  logic               isFull;
  logic               pushOk;

  assign isFull    = (level == LEVEL_W'(DEPTH));
  assign popEn     = popReq && (level != '0);
  assign pushOk    = strobe.stopPush && (!isFull || popEn);
  assign headEntry = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (pushOk) mem[wrPtr] <= newEntry;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      level   <= '0;
      overrun <= 1'b0;
    end else begin
      if (pushOk) wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + PTR_W'(1);
      if (popEn)  rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + PTR_W'(1);
      case ({pushOk, popEn})
        2'b10:   level <= level + LEVEL_W'(1);
        2'b01:   level <= level - LEVEL_W'(1);
        default: level <= level;
      endcase
      if (strobe.stopPush && !pushOk) overrun <= 1'b1;
      else if (popReq)                overrun <= 1'b0;
    end
  end

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    level <= LEVEL_W'(DEPTH)); // R5

  AST_OVR_ON_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stopPush && isFull && !popReq) |=> (overrun && level == LEVEL_W'(DEPTH))); // R8

  AST_POP_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    (popEn && !strobe.stopPush) |=> (level == $past(level) - LEVEL_W'(1))); // R6

endmodule

// File: rtl/uart_rx_path.sv
module uart_rx_path
  import uart_rx_pkg::*;
#(
  parameter int DEPTH   = 32,
  parameter int LEVEL_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sampleTick,
  input  logic               rxIn,
  input  logic [1:0]         osMode,
  input  logic [1:0]         wordLen,
  input  logic               parityEn,
  input  logic               parityOdd,
  input  logic               twoStop,
  input  logic               trigMode,
  input  logic [1:0]         trigSel,
  input  logic               readStrobe,
  output logic [7:0]         headData,
  output logic               headParErr,
  output logic               headFrmErr,
  output logic               headBrk,
  output logic               overrun,
  output logic [LEVEL_W-1:0] level,
  output logic               dataReady,
  output logic               timeout
);

  localparam int TRIG_N = 4;

  rxStrobeT strobe;
  rxEntryT  headEntry;
  logic     popEn;

  uart_rx_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sampleTick (sampleTick),
    .rxIn       (rxIn),
    .osMode     (osMode),
    .wordLen    (wordLen),
    .parityEn   (parityEn),
    .twoStop    (twoStop),
    .popEn      (popEn),
    .levelZero  (level == '0),
    .strobe     (strobe),
    .timeout    (timeout)
  );

  uart_rx_dp #(.DEPTH(DEPTH)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .rxIn      (rxIn),
    .strobe    (strobe),
    .wordLen   (wordLen),
    .parityEn  (parityEn),
    .parityOdd (parityOdd),
    .popReq    (readStrobe),
    .headEntry (headEntry),
    .level     (level),
    .overrun   (overrun),
    .popEn     (popEn)
  );

  // Threshold table: 2/8, 4/8, 6/8 and 7/8 of the depth.
  logic [LEVEL_W-1:0] trigTab [TRIG_N];
  for (genvar g = 0; g < TRIG_N; g++) begin : g_trig
    localparam int NUMER = (g == TRIG_N - 1) ? 7 : 2 * (g + 1);
    assign trigTab[g] = LEVEL_W'((DEPTH * NUMER) / 8);
  end

  assign dataReady  = trigMode ? (level >= trigTab[trigSel]) : (level != '0);
  assign headData   = headEntry.data;
  assign headParErr = headEntry.parErr;
  assign headFrmErr = headEntry.frmErr;
  assign headBrk    = headEntry.brk;

endmodule

// File: tb/uart_rx_path_tb.sv
module uart_rx_path_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sampleTick = 1'b1;
  logic       rxIn = 1'b1;
  logic [1:0] osMode = 2'd0;
  logic [1:0] wordLen = 2'd3;
  logic       parityEn = 1'b0;
  logic       parityOdd = 1'b0;
  logic       twoStop = 1'b0;
  logic       trigMode = 1'b0;
  logic [1:0] trigSel = 2'd0;
  logic       readStrobe = 1'b0;
  logic [7:0] headData;
  logic       headParErr, headFrmErr, headBrk, overrun, dataReady, timeout;
  logic [5:0] level;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  uart_rx_path dut_i (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rxIn(rxIn),
    .osMode(osMode), .wordLen(wordLen), .parityEn(parityEn),
    .parityOdd(parityOdd), .twoStop(twoStop), .trigMode(trigMode),
    .trigSel(trigSel), .readStrobe(readStrobe), .headData(headData),
    .headParErr(headParErr), .headFrmErr(headFrmErr), .headBrk(headBrk),
    .overrun(overrun), .level(level), .dataReady(dataReady), .timeout(timeout)
  );

  typedef struct packed {
    logic [1:0] os;
    logic [1:0] wl;
    logic       pe;
    logic       po;
    logic       bad;
    logic       stopV;
    logic [7:0] d;
    logic       ePe;
    logic       eFe;
    logic       eBk;
  } vecT;

  localparam int NVEC = 7;
  localparam vecT VECS [NVEC] = '{
    '{2'd0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 8'hA5, 1'b0, 1'b0, 1'b0},
    '{2'd1, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 8'h5A, 1'b0, 1'b0, 1'b0},
    '{2'd2, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 8'h13, 1'b1, 1'b0, 1'b0},
    '{2'd0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 8'h3C, 1'b0, 1'b1, 1'b0},
    '{2'd0, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1},
    '{2'd1, 2'd1, 1'b1, 1'b1, 1'b0, 1'b1, 8'h2D, 1'b0, 1'b0, 1'b0},
    '{2'd1, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 8'hFF, 1'b0, 1'b1, 1'b0}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int ticksOf(input logic [1:0] m);
    return (m == 2'd0) ? 16 : (m == 2'd1) ? 8 : 4;
  endfunction

  // Called at a negedge; drives a complete frame, one bit per 'full' cycles.
  task automatic sendFrame(input logic [7:0] d, input int nb, input bit pe,
                           input bit po, input bit bad, input bit stopV,
                           input bit two, input int full);
    logic par;
    par = 1'b0;
    rxIn = 1'b0;
    repeat (full) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      rxIn = d[i];
      par  = par ^ d[i];
      repeat (full) @(negedge clk);
    end
    if (pe) begin
      rxIn = par ^ po ^ bad;
      repeat (full) @(negedge clk);
    end
    rxIn = stopV;
    repeat (full) @(negedge clk);
    if (two) begin
      rxIn = 1'b1;
      repeat (full) @(negedge clk);
    end
    rxIn = 1'b1;
  endtask

  task automatic popOne();
    readStrobe = 1'b1;
    @(negedge clk);
    readStrobe = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(level == 0 && !dataReady && !timeout && !overrun, "R5", "reset state",
          {level, dataReady, timeout, overrun}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // Table of frames: modes, lengths, parity and error tags (R1 R3 R4 R7)
    for (int v = 0; v < NVEC; v++) begin
      osMode = VECS[v].os; wordLen = VECS[v].wl;
      parityEn = VECS[v].pe; parityOdd = VECS[v].po;
      @(negedge clk);
      sendFrame(VECS[v].d, 5 + int'(VECS[v].wl), VECS[v].pe, VECS[v].po,
                VECS[v].bad, VECS[v].stopV, 1'b0, ticksOf(VECS[v].os));
      repeat (2) @(negedge clk);
      check(level == 1, "R1", "level after frame", level, 1);
      check(headData == VECS[v].d, "R3", "data", headData, VECS[v].d);
      check(headParErr == VECS[v].ePe, "R4", "parity tag", headParErr, VECS[v].ePe);
      check(headFrmErr == VECS[v].eFe && headBrk == VECS[v].eBk, "R7", "frame/break tags",
            {headFrmErr, headBrk}, {VECS[v].eFe, VECS[v].eBk});
      popOne();
      check(level == 0, "R6", "level after read", level, 0);
    end

    // False start in 16X and 4X (R2)
    osMode = 2'd0; wordLen = 2'd3; parityEn = 1'b0;
    rxIn = 1'b0; repeat (3) @(negedge clk); rxIn = 1'b1;
    repeat (40) @(negedge clk);
    check(level == 0, "R2", "false start 16X stored", level, 0);
    osMode = 2'd2;
    @(negedge clk);
    rxIn = 1'b0; @(negedge clk); rxIn = 1'b1;
    repeat (20) @(negedge clk);
    check(level == 0, "R2", "false start 4X stored", level, 0);

    // Tags switch at once with the head (R6)
    parityEn = 1'b1; parityOdd = 1'b0;
    @(negedge clk);
    sendFrame(8'h11, 8, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 4);
    sendFrame(8'h22, 8, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4);
    @(negedge clk);
    check(headData == 8'h11 && headParErr, "R6", "first head", {headParErr, headData}, 9'h111);
    popOne();
    check(headData == 8'h22 && !headParErr, "R6", "next head after read",
          {headParErr, headData}, 9'h022);
    popOne();

    // Data-ready modes (R9)
    parityEn = 1'b0; trigMode = 1'b0;
    @(negedge clk);
    sendFrame(8'h40, 8, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4);
    @(negedge clk);
    check(dataReady, "R9", "ready on one char", dataReady, 1);
    trigMode = 1'b1; trigSel = 2'd0;
    @(negedge clk);
    check(!dataReady, "R9", "threshold 8 with 1", dataReady, 0);
    for (int i = 1; i < 7; i++) sendFrame(8'h40 + 8'(i), 8, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4);
    @(negedge clk);
    check(!dataReady && level == 7, "R9", "threshold 8 with 7", {level, dataReady}, 14);
    sendFrame(8'h47, 8, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4);
    @(negedge clk);
    check(dataReady, "R9", "threshold 8 with 8", dataReady, 1);
    trigSel = 2'd1;
    @(negedge clk);
    check(!dataReady, "R9", "threshold 16 with 8", dataReady, 0);
    for (int i = 0; i < 8; i++) begin
      check(headData == 8'h40 + 8'(i), "R5", "order", headData, 8'h40 + i);
      popOne();
    end
    trigMode = 1'b0;

    // Fill, overrun, and same-edge store with read (R8)
    for (int i = 0; i < 32; i++) sendFrame(8'(i * 7 + 3), 8, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4);
    @(negedge clk);
    check(level == 32 && !overrun, "R5", "full level", level, 32);
    sendFrame(8'hDD, 8, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4);
    @(negedge clk);
    check(level == 32 && overrun, "R8", "overrun when full", {overrun, level}, 7'h60);
    popOne();
    check(level == 31 && !overrun, "R8", "overrun cleared by read", {overrun, level}, 31);
    sendFrame(8'hEE, 8, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4);
    @(negedge clk);
    fork
      sendFrame(8'h77, 8, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4);
      begin
        repeat (38) @(negedge clk);
        readStrobe = 1'b1;
        @(negedge clk);
        readStrobe = 1'b0;
      end
    join
    @(negedge clk);
    check(level == 32 && !overrun, "R8", "store with read on full", {overrun, level}, 32);
    for (int i = 0; i < 32; i++) begin
      logic [7:0] expD;
      expD = (i < 30) ? 8'((i + 2) * 7 + 3) : ((i == 30) ? 8'hEE : 8'h77);
      check(headData == expD, "R8", "drain order", headData, expD);
      popOne();
    end
    check(level == 0, "R5", "drained", level, 0);

    // Timeout: 4X, 8 data, parity, two stops -> 12 frame bits, 60 bit periods, 240 ticks (R10)
    parityEn = 1'b1; twoStop = 1'b1;
    @(negedge clk);
    fork
      sendFrame(8'h5C, 8, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 4);
      begin
        while (level == 0) @(negedge clk);
        repeat (236) @(negedge clk);
        check(!timeout, "R10", "timeout early", timeout, 0);
        repeat (8) @(negedge clk);
        check(timeout, "R10", "timeout after limit", timeout, 1);
      end
    join
    popOne();
    check(!timeout && level == 0, "R11", "timeout cleared by read", timeout, 0);
    repeat (300) @(negedge clk);
    check(!timeout, "R11", "no timeout while empty", timeout, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule